// File: doc/BRIEF.md
# Zero-Suppressing Multiplexed Readout Sequencer

This block runs one front-end card that carries 64 detector channels on four 16-channel analog multiplexing chips. Two serial 12-bit converters digitise the analog streams. Converter 0 sees the first two chips (channels 0 to 31) and converter 1 sees the last two (channels 32 to 63), so one multiplexer position yields two samples at once. A trigger starts a pass. The sequencer holds the analog levels and reads the converters bit by bit. It steps the multiplexers through 32 positions and then clears the analog chips.

Each sample has a per-channel pedestal subtracted from it and is compared against a per-channel threshold. Samples that pass are packed with the card address and the channel number. They leave as three bytes on a byte-wide link. Several cards share that link by passing a token. A card sends only while it holds the token, and it hands the token on once its pass is over. A card that is idle forwards the token at once. The pedestal and threshold tables are loaded through a small write port while the card is idle.

Top module: `zs_readout_seq`

## Requirements
- R1: After reset `busy`, `trackHold`, `clearOut`, `muxClk`, `adcSel`, `adcClk`, `tokenOut` and `linkValid` are all low.
- R2: A `trigger` seen while idle raises `busy` and `trackHold` in the next cycle. A `trigger` seen while `busy` is high is ignored: a pass has exactly one rising edge of `trackHold` and exactly 31 `muxClk` pulses.
- R3: Each conversion raises `adcSel` for exactly 24 cycles. Inside that window `adcClk` alternates low then high, 12 times. A data bit is taken on each cycle in which `adcClk` is high, most significant bit first. `adcClk` is never high outside the window. There are 32 windows per pass.
- R4: Multiplexer position k (0..31, advanced by each `muxClk`) gives channel k from `adcData[0]` and channel k+32 from `adcData[1]`. Words are emitted in the order channel k, then channel k+32, for k ascending.
- R5: The value sent is the sample minus the channel's pedestal, or 0 when the sample is below the pedestal.
- R6: A channel is sent if and only if its corrected value is greater than or equal to its threshold. A threshold of 0 keeps every sample.
- R7: A word is 24 bits, made of `cardAddr` in bits 23:18, the channel in bits 17:12 and the corrected value in bits 11:0. It goes out as three consecutive `linkValid` bytes, starting with bits 23:16.
- R8: `linkValid` is high only while the card holds the token, that is, after a `tokenIn` pulse received while busy. Without the token, output stalls and no data is lost.
- R9: After the last position, `clearOut` pulses exactly once. Then `tokenOut` pulses exactly once, as soon as the token is held, and the card returns to idle. This holds even when no channel survives.
- R10: A `tokenIn` pulse seen while idle appears on `tokenOut` in the next cycle.
- R11: `cfgWe` writes `cfgData` into the threshold table (`cfgSel`=1) or the pedestal table (`cfgSel`=0) at `cfgAddr`, and only while idle. Writes while `busy` is high are ignored.
- R12: `busy` stays high from the cycle after an accepted trigger until the token has been passed on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Start of a conversion pass |
| busy | output | 1 | Pass in progress |
| trackHold | output | 1 | Hold strobe to the analog chips |
| clearOut | output | 1 | Clear pulse to the analog chips |
| muxClk | output | 1 | Advances the analog multiplexers one position |
| adcClk | output | 1 | Serial clock to both converters |
| adcSel | output | 1 | Converter select, high during one conversion |
| adcData | input | 2 | Serial data, bit g from converter g |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 1 | 1 selects threshold, 0 selects pedestal |
| cfgAddr | input | 6 | Channel to write |
| cfgData | input | 12 | Value to write |
| cardAddr | input | 6 | Card address placed in each word |
| tokenIn | input | 1 | Token arrival pulse |
| tokenOut | output | 1 | Token hand-off pulse |
| linkValid | output | 1 | Byte on `linkData` is valid |
| linkData | output | 8 | Output byte |

## Verification
On every cycle the assertions check these properties: the converter clock stays inside its select window, the multiplexer, clear and select strobes never overlap, and the clear is a single-cycle pulse. They also check that link bytes appear only while a token is held, that an idle card forwards the token, and that a pass starts only from a trigger. Only the bench scenarios can show the data content: the pedestal floor at zero, the keep-or-drop decision at the threshold boundary, the channel order and the byte packing, and the fact that a table write made during a pass leaves its results unchanged. The bench compares every byte against a stream it builds from its own copy of the tables.

// File: rtl/zs_readout_pkg.sv
package zs_readout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_CONV, ST_EMIT, ST_STEP, ST_CLEAR, ST_PASS
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       shiftEn;
    logic       lane;
    logic       sendByte;
    logic [1:0] byteIdx;
    logic       stepInc;
    logic       stepClr;
  } dpCtl_t;

endpackage

// File: rtl/zs_readout_ctrl.sv
module zs_readout_ctrl
  import zs_readout_pkg::*;
#(
  parameter int ADC_BITS   = 12,
  parameter int LINK_BYTES = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   trigger,
  input  logic   tokenIn,
  input  logic   keep,
  input  logic   lastStep,
  output logic   busy,
  output logic   trackHold,
  output logic   clearOut,
  output logic   muxClk,
  output logic   adcClk,
  output logic   adcSel,
  output logic   tokenOut,
  output dpCtl_t ctl
);
  localparam int BIT_W = $clog2(ADC_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(ADC_BITS - 1);
  localparam logic [1:0] LAST_BYTE = 2'(LINK_BYTES - 1);

  seqState_t state;
  logic phase, lane, hasToken, tokenOutR, laneDone;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0] byteIdx;

  always_comb begin
    ctl.shiftEn  = (state == ST_CONV) && phase;
    ctl.lane     = lane;
    ctl.sendByte = (state == ST_EMIT) && keep && hasToken;
    ctl.byteIdx  = byteIdx;
    ctl.stepInc  = (state == ST_STEP);
    ctl.stepClr  = (state == ST_HOLD);
    laneDone     = (state == ST_EMIT) &&
                   (!keep || (hasToken && byteIdx == LAST_BYTE));
  end

  assign busy      = (state != ST_IDLE);
  assign trackHold = (state == ST_HOLD) || (state == ST_CONV) ||
                     (state == ST_EMIT) || (state == ST_STEP);
  assign clearOut  = (state == ST_CLEAR);
  assign muxClk    = (state == ST_STEP);
  assign adcSel    = (state == ST_CONV);
  assign adcClk    = (state == ST_CONV) && phase;
  assign tokenOut  = tokenOutR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      lane      <= 1'b0;
      bitCnt    <= '0;
      byteIdx   <= '0;
      hasToken  <= 1'b0;
      tokenOutR <= 1'b0;
    end else begin
      tokenOutR <= ((state == ST_IDLE) && tokenIn) ||
                   ((state == ST_PASS) && hasToken);
      if ((state == ST_PASS) && hasToken) hasToken <= 1'b0;
      else if (tokenIn && (state != ST_IDLE)) hasToken <= 1'b1;

      unique case (state)
        ST_IDLE: if (trigger) state <= ST_HOLD;
        ST_HOLD, ST_STEP: begin
          state  <= ST_CONV;
          phase  <= 1'b0;
          bitCnt <= '0;
        end
        ST_CONV: begin
          phase <= ~phase;
          if (phase) begin
            if (bitCnt == LAST_BIT) begin
              state   <= ST_EMIT;
              lane    <= 1'b0;
              byteIdx <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_EMIT: begin
          if (laneDone) begin
            byteIdx <= '0;
            if (lane) state <= lastStep ? ST_CLEAR : ST_STEP;
            else      lane  <= 1'b1;
          end else if (ctl.sendByte) begin
            byteIdx <= byteIdx + 1'b1;
          end
        end
        ST_CLEAR: state <= ST_PASS;
        ST_PASS:  if (hasToken) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zs_readout_dp.sv
module zs_readout_dp
  import zs_readout_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int ADC_BITS = 12,
  parameter int CARD_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [1:0]                adcData,
  input  logic                      cfgWe,
  input  logic                      cfgSel,
  input  logic [$clog2(NUM_CH)-1:0] cfgAddr,
  input  logic [ADC_BITS-1:0]       cfgData,
  input  logic                      cfgOk,
  input  logic [CARD_W-1:0]         cardAddr,
  output logic                      keep,
  output logic                      lastStep,
  output logic                      linkValid,
  output logic [7:0]                linkData
);
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int HALF   = NUM_CH / 2;
  localparam int STEP_W = $clog2(HALF);
  localparam int WORD_W = CARD_W + ADDR_W + ADC_BITS;
  localparam int NBYTES = (WORD_W + 7) / 8;

  logic [ADC_BITS-1:0] pedTab [NUM_CH];
  logic [ADC_BITS-1:0] thrTab [NUM_CH];
  logic [ADC_BITS-1:0] shReg  [2];
  logic [STEP_W-1:0]   step;
  logic [ADDR_W-1:0]   chan;
  logic [ADC_BITS-1:0] raw, ped, thr, corr;
  logic [NBYTES*8-1:0] wordPad;
  logic [1:0]          byteSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        pedTab[i] <= '0;
        thrTab[i] <= '0;
      end
    end else if (cfgWe && cfgOk) begin
      if (cfgSel) thrTab[cfgAddr] <= cfgData;
      else        pedTab[cfgAddr] <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            step <= '0;
    else if (ctl.stepClr) step <= '0;
    else if (ctl.stepInc) step <= step + 1'b1;
  end
  assign lastStep = (step == STEP_W'(HALF - 1));

  for (genvar g = 0; g < 2; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)            shReg[g] <= '0;
      else if (ctl.shiftEn) shReg[g] <= {shReg[g][ADC_BITS-2:0], adcData[g]};
    end
  end

  always_comb begin
    chan    = {ctl.lane, step};
    raw     = shReg[ctl.lane];
    ped     = pedTab[chan];
    thr     = thrTab[chan];
    corr    = (raw >= ped) ? (raw - ped) : '0;
    keep    = (corr >= thr);
    wordPad = '0;
    wordPad[WORD_W-1:0] = {cardAddr, chan, corr};
    byteSel = 2'(NBYTES - 1) - ctl.byteIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkValid <= 1'b0;
      linkData  <= '0;
    end else begin
      linkValid <= ctl.sendByte;
      if (ctl.sendByte) linkData <= wordPad[8*byteSel +: 8];
    end
  end
endmodule

// File: rtl/zs_readout_seq.sv
module zs_readout_seq
  import zs_readout_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int ADC_BITS = 12,
  parameter int CARD_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      trigger,
  output logic                      busy,
  output logic                      trackHold,
  output logic                      clearOut,
  output logic                      muxClk,
  output logic                      adcClk,
  output logic                      adcSel,
  input  logic [1:0]                adcData,
  input  logic                      cfgWe,
  input  logic                      cfgSel,
  input  logic [$clog2(NUM_CH)-1:0] cfgAddr,
  input  logic [ADC_BITS-1:0]       cfgData,
  input  logic [CARD_W-1:0]         cardAddr,
  input  logic                      tokenIn,
  output logic                      tokenOut,
  output logic                      linkValid,
  output logic [7:0]                linkData
);
  localparam int WORD_W = CARD_W + $clog2(NUM_CH) + ADC_BITS;

  dpCtl_t ctl;
  logic keep, lastStep;

  zs_readout_ctrl #(.ADC_BITS(ADC_BITS), .LINK_BYTES((WORD_W + 7) / 8)) uCtrl (
    .clk, .rstN, .trigger, .tokenIn, .keep, .lastStep, .busy, .trackHold,
    .clearOut, .muxClk, .adcClk, .adcSel, .tokenOut, .ctl
  );

  zs_readout_dp #(.NUM_CH(NUM_CH), .ADC_BITS(ADC_BITS), .CARD_W(CARD_W)) uDp (
    .clk, .rstN, .ctl, .adcData, .cfgWe, .cfgSel, .cfgAddr, .cfgData,
    .cfgOk(!busy), .cardAddr, .keep, .lastStep, .linkValid, .linkData
  );
endmodule

// File: rtl/zs_readout_seq_chk.sv
module zs_readout_seq_chk (
  input logic clk,
  input logic rstN,
  input logic trigger,
  input logic busy,
  input logic trackHold,
  input logic clearOut,
  input logic muxClk,
  input logic adcClk,
  input logic adcSel,
  input logic tokenIn,
  input logic tokenOut,
  input logic linkValid
);
  logic tokHeld;
  always_ff @(posedge clk) begin
    if (!rstN)                tokHeld <= 1'b0;
    else if (tokenOut)        tokHeld <= 1'b0;
    else if (tokenIn && busy) tokHeld <= 1'b1;
  end

  assert_adcclk_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    adcClk |-> adcSel);
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({muxClk, clearOut, adcSel}));
  assert_clear_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearOut |=> !clearOut);
  assert_link_needs_token_R8: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |-> tokHeld);
  assert_idle_token_pass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && tokenIn) |=> tokenOut);
  assert_start_on_trigger_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigger));
  assert_hold_implies_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    trackHold |-> busy);
endmodule

bind zs_readout_seq zs_readout_seq_chk uChk (.*);

// File: tb/zs_readout_seq_test.sv
module zs_readout_seq_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, trigger, busy, trackHold, clearOut, muxClk, adcClk, adcSel;
  logic [1:0] adcData;
  logic cfgWe, cfgSel, tokenIn, tokenOut, linkValid;
  logic [5:0] cfgAddr, cardAddr;
  logic [11:0] cfgData;
  logic [7:0] linkData;

  zs_readout_seq uut (.*);

  int nChk = 0, nFail = 0;
  logic [11:0] pedB [64];
  logic [11:0] thrB [64];
  logic [11:0] rawB [64];
  logic [7:0] rx [1024];
  logic [7:0] expB [256];
  int expN;
  int rxCnt = 0, muxCnt = 0, clrCnt = 0, tokCnt = 0, thRise = 0;
  int selWin = 0, selBad = 0, selLen = 0, early = 0, stepIdx = 0, bitIdx = 0;
  int cyc = 0, clrCyc = 0, tokCyc = 0;
  bit tokGiven = 0, prevTh = 0, prevSel = 0, prevClk = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail + 1);
      $finish;
    end
  end

  // monitor and serial converter model
  always @(negedge clk) begin
    if (rstN) begin
      if (linkValid) begin
        rx[rxCnt % 1024] = linkData;
        rxCnt++;
        if (!tokGiven) early++;
      end
      if (muxClk) begin muxCnt++; stepIdx++; end
      if (clearOut) begin clrCnt++; stepIdx = 0; clrCyc = cyc; end
      if (tokenOut) begin tokCnt++; tokCyc = cyc; end
      if (trackHold && !prevTh) thRise++;
      if (adcSel) selLen++;
      else if (prevSel) begin
        selWin++;
        if (selLen != 24) selBad++;
        selLen = 0;
      end
      if (!adcSel) bitIdx = 0;
      else if (prevClk && !adcClk) bitIdx++;
      adcData[0] = (bitIdx < 12) ? rawB[stepIdx & 31][11 - bitIdx] : 1'b0;
      adcData[1] = (bitIdx < 12) ? rawB[(stepIdx & 31) + 32][11 - bitIdx] : 1'b0;
      prevTh = trackHold; prevSel = adcSel; prevClk = adcClk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit sel, input int ch, input int val);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgAddr = 6'(ch); cfgData = 12'(val);
    if (sel) thrB[ch] = 12'(val); else pedB[ch] = 12'(val);
    @(negedge clk);
    cfgWe = 0;
  endtask

  function automatic int corrOf(input int ch);
    return (rawB[ch] >= pedB[ch]) ? int'(rawB[ch]) - int'(pedB[ch]) : 0;
  endfunction

  task automatic buildExpected();
    expN = 0;
    for (int k = 0; k < 32; k++) begin
      for (int ln = 0; ln < 2; ln++) begin
        int ch = ln * 32 + k;
        int c  = corrOf(ch);
        if (c >= int'(thrB[ch])) begin
          int w = (int'(cardAddr) << 18) | (ch << 12) | c;
          expB[expN]     = 8'(w >> 16);
          expB[expN + 1] = 8'(w >> 8);
          expB[expN + 2] = 8'(w);
          expN += 3;
        end
      end
    end
  endtask

  task automatic doRun(input int tokDelay, input int busyWrCh, input string nm);
    int sRx = rxCnt, sMux = muxCnt, sClr = clrCnt, sTok = tokCnt, sTh = thRise;
    int sSw = selWin, sSb = selBad, sEarly = early, waitN = 0, bad = 0;
    buildExpected();
    tokGiven = 0;
    @(negedge clk); trigger = 1;
    @(negedge clk); trigger = 0;
    check(busy === 1'b1, {nm, " R12 busy after trigger"}, busy, 1);
    check(trackHold === 1'b1, {nm, " R2 hold after trigger"}, trackHold, 1);
    repeat (tokDelay) @(negedge clk);
    tokenIn = 1; tokGiven = 1;
    @(negedge clk); tokenIn = 0;
    repeat (20) @(negedge clk);
    trigger = 1;
    if (busyWrCh >= 0) begin
      cfgWe = 1; cfgSel = 1; cfgAddr = 6'(busyWrCh); cfgData = 12'hFFF;
    end
    @(negedge clk); trigger = 0; cfgWe = 0;
    while (busy && waitN < 30000) begin @(negedge clk); waitN++; end
    repeat (3) @(negedge clk);
    check(rxCnt - sRx == expN, {nm, " R6 byte count"}, rxCnt - sRx, expN);
    for (int i = 0; i < expN && i < rxCnt - sRx; i++)
      if (rx[(sRx + i) % 1024] !== expB[i]) begin
        if (bad == 0)
          check(0, {nm, " R4 R5 R7 R11 byte content"}, rx[(sRx + i) % 1024], expB[i]);
        bad++;
      end
    if (bad == 0) check(1, {nm, " R4 R5 R7 R11 byte content"}, 0, 0);
    check(muxCnt - sMux == 31, {nm, " R2 R4 mux steps"}, muxCnt - sMux, 31);
    check(thRise - sTh == 1, {nm, " R2 retrigger ignored"}, thRise - sTh, 1);
    check(selWin - sSw == 32 && selBad == sSb, {nm, " R3 converter windows"},
          selWin - sSw, 32);
    check(clrCnt - sClr == 1, {nm, " R9 clear count"}, clrCnt - sClr, 1);
    check(tokCnt - sTok == 1, {nm, " R9 token out count"}, tokCnt - sTok, 1);
    check(tokCyc > clrCyc, {nm, " R9 token after clear"}, tokCyc, clrCyc + 1);
    check(early == sEarly, {nm, " R8 no bytes without token"}, early - sEarly, 0);
    check(busy === 1'b0, {nm, " R12 idle at end"}, busy, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 0; trigger = 0; cfgWe = 0; cfgSel = 0; cfgAddr = 0; cfgData = 0;
    tokenIn = 0; adcData = 0; cardAddr = 6'h2B;
    for (int i = 0; i < 64; i++) begin pedB[i] = 0; thrB[i] = 0; rawB[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check({busy, trackHold, clearOut, muxClk, adcSel, adcClk, tokenOut, linkValid} === 8'h00,
          "R1 reset outputs", {busy, trackHold, clearOut, muxClk, adcSel, adcClk, tokenOut,
          linkValid}, 0);

    // R10 idle pass-through
    tokenIn = 1;
    @(negedge clk); tokenIn = 0;
    check(tokenOut === 1'b1, "R10 idle token forwarded", tokenOut, 1);
    @(negedge clk);
    check(tokenOut === 1'b0, "R10 token pulse single", tokenOut, 0);

    // random tables with directed corners
    for (int i = 0; i < 64; i++) begin
      cfgWrite(0, i, $urandom_range(300));
      cfgWrite(1, i, $urandom_range(200));
      rawB[i] = 12'($urandom_range(1023));
    end
    cfgWrite(0, 1, 50);  cfgWrite(1, 1, 0);   rawB[1]  = 10;   // floor at zero, kept
    cfgWrite(0, 2, 50);  cfgWrite(1, 2, 150); rawB[2]  = 200;  // equal to threshold
    cfgWrite(0, 3, 50);  cfgWrite(1, 3, 151); rawB[3]  = 200;  // one below threshold
    cfgWrite(0, 33, 0);  cfgWrite(1, 33, 4095); rawB[33] = 4095;
    doRun(3, 2, "runA");

    for (int i = 0; i < 64; i++) rawB[i] = 12'($urandom_range(1023));
    rawB[2] = 200;
    doRun(400, -1, "runB");

    for (int i = 0; i < 64; i++) begin
      cfgWrite(1, i, 4095);
      rawB[i] = 12'($urandom_range(1023));
    end
    doRun(5, -1, "runC");

    for (int i = 0; i < 64; i++) begin
      cfgWrite(0, i, 0); cfgWrite(1, i, 0);
      rawB[i] = 12'($urandom_range(4095));
    end
    rawB[0] = 12'hFFF; rawB[63] = 0;
    doRun(2, -1, "runD");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule